// File: doc/BRIEF.md
# CAN Fault Confinement Error Counters

This block holds the two error counters that a CAN node uses to decide how far it may still take part in bus traffic, and it decodes the node's error state from them. The protocol engine sends it single-cycle pulses. A transmit error raises the transmit counter by a large step, and a good transmission lowers it by one. A receive error raises the receive counter by a small or a large step, chosen by a severity flag, and a good reception lowers it by one. If the receive counter is above 128 when a good reception arrives, it is loaded with 120 instead of being lowered.

Three registered, mutually exclusive flags report the state: error active, error passive and bus-off. Bus-off is entered when the transmit counter reaches 256. The state then holds, and every counter event is ignored, until the engine sends a recovery pulse. That pulse clears both counters and puts the node back into error active. Counters and flags change on the same clock edge that samples the event pulse.

Top module: `can_fault_counters`

## Requirements
- R1: After reset both counters read 0 and only the error-active flag is set.
- R2: A transmit error pulse adds 8 to the 9-bit transmit counter.
- R3: A transmit success pulse subtracts 1 from the transmit counter, and the counter stays at 0 when it is already 0.
- R4: A receive error pulse adds 1 to the 8-bit receive counter when `rx_err_major` is 0 and adds 8 when it is 1. The result saturates at 255.
- R5: A receive success pulse loads 120 into the receive counter when it is above 128. Otherwise it subtracts 1, and the counter stays at 0 when it is already 0.
- R6: When an error pulse and a success pulse for the same counter arrive in the same cycle, only the error pulse takes effect.
- R7: Outside bus-off, the error-passive flag is set when either counter is above 127, and the error-active flag is set when both counters are 127 or below.
- R8: The bus-off flag is set when the transmit counter reaches 256 or more.
- R9: In bus-off, all counter event pulses are ignored, and both counters and the state hold until a recovery pulse arrives.
- R10: A recovery pulse in bus-off clears both counters and selects error active. A recovery pulse in any other state has no effect.
- R11: Exactly one of the three state flags is set in every cycle. The flags change on the same edge as the counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_err | input | 1 | Transmit error event pulse |
| tx_ok | input | 1 | Transmit success event pulse |
| rx_err | input | 1 | Receive error event pulse |
| rx_err_major | input | 1 | Severity of the receive error: 1 selects the step of 8, 0 the step of 1 |
| rx_ok | input | 1 | Receive success event pulse |
| recover | input | 1 | Return from bus-off |
| tx_cnt | output | 9 | Transmit error counter |
| rx_cnt | output | 8 | Receive error counter |
| st_active | output | 1 | Error-active flag |
| st_passive | output | 1 | Error-passive flag |
| st_busoff | output | 1 | Bus-off flag |

## Verification
Directed sequences walk each counter to the edges where its behaviour changes:
- the transmit counter is pushed from 0 through 127/128 into 256, which separates the passive and bus-off thresholds;
- the receive counter is driven to 255 with major errors, then walked back with successes across 129, 128 and 0, which separates the snap-to-120 load from the plain decrement and from the floor at 0;
- simultaneous error and success pulses show the priority;
- pulses sent during bus-off, and a recovery sent outside it, show which events are dropped.

A long pseudo-random stream then mixes every pulse, biased so that the node drifts into bus-off and recovers many times. An arithmetic model in the bench predicts each counter and flag after every cycle.

// File: rtl/can_fc_pkg.sv
package can_fc_pkg;
  typedef enum logic [1:0] {
    FC_ACTIVE  = 2'd0,
    FC_PASSIVE = 2'd1,
    FC_BUSOFF  = 2'd2
  } fc_state_e;
endpackage

// File: rtl/fc_tx_counter.sv
module fc_tx_counter #(
  parameter int W  = 9,
  parameter int UP = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         freeze,
  input  logic         clr,
  input  logic         inc,
  input  logic         dec,
  output logic [W-1:0] cnt_q,
  output logic [W-1:0] cnt_d
);
  localparam logic [W:0] MAXV   = {1'b0, {W{1'b1}}};
  localparam int         SAT_AT = (2**W) - UP;

  logic [W:0] sum;
  logic       en;

  always_comb begin
    sum   = {1'b0, cnt_q} + (W+1)'(UP);
    en    = clr | (!freeze & (inc | dec));
    cnt_d = cnt_q;
    if (clr)
      cnt_d = '0;
    else if (!freeze && inc)
      cnt_d = (sum > MAXV) ? {W{1'b1}} : sum[W-1:0];
    else if (!freeze && dec)
      cnt_d = (cnt_q == '0) ? '0 : cnt_q - W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (en)
      cnt_q <= cnt_d;
  end

  // R2: error step adds the full increment
  a_r2_tx_step: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !freeze && !clr && cnt_q < W'(SAT_AT)) |=> cnt_q == $past(cnt_q) + W'(UP));
  // R3: success alone lowers by one, never below zero
  a_r3_tx_down: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !inc && !freeze && !clr && cnt_q != '0) |=> cnt_q == $past(cnt_q) - W'(1));
endmodule

// File: rtl/fc_rx_counter.sv
module fc_rx_counter #(
  parameter int W          = 8,
  parameter int STEP_MINOR = 1,
  parameter int STEP_MAJOR = 8,
  parameter int SNAP_ABOVE = 128,
  parameter int SNAP_TO    = 120
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         freeze,
  input  logic         clr,
  input  logic         inc,
  input  logic         major,
  input  logic         dec,
  output logic [W-1:0] cnt_q,
  output logic [W-1:0] cnt_d
);
  localparam logic [W:0] MAXV = {1'b0, {W{1'b1}}};

  logic [W:0] sum;
  logic       en;

  always_comb begin
    sum   = {1'b0, cnt_q} + (major ? (W+1)'(STEP_MAJOR) : (W+1)'(STEP_MINOR));
    en    = clr | (!freeze & (inc | dec));
    cnt_d = cnt_q;
    if (clr)
      cnt_d = '0;
    else if (!freeze && inc)
      cnt_d = (sum > MAXV) ? {W{1'b1}} : sum[W-1:0];
    else if (!freeze && dec) begin
      if (cnt_q > W'(SNAP_ABOVE))
        cnt_d = W'(SNAP_TO);
      else if (cnt_q != '0)
        cnt_d = cnt_q - W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (en)
      cnt_q <= cnt_d;
  end

  // R5: success above the snap limit reloads the fixed value
  a_r5_rx_snap: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !inc && !freeze && !clr && cnt_q > W'(SNAP_ABOVE)) |=> cnt_q == W'(SNAP_TO));
  // R4: counter holds at its ceiling under further errors
  a_r4_rx_sat: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !freeze && !clr && cnt_q == {W{1'b1}}) |=> cnt_q == {W{1'b1}});
endmodule

// File: rtl/fc_state_fsm.sv
module fc_state_fsm
  import can_fc_pkg::*;
#(
  parameter int TEC_W         = 9,
  parameter int REC_W         = 8,
  parameter int PASSIVE_ABOVE = 127,
  parameter int BUSOFF_AT     = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             recover,
  input  logic [TEC_W-1:0] tec_d,
  input  logic [REC_W-1:0] rec_d,
  output logic             busoff,
  output logic             f_active,
  output logic             f_passive,
  output logic             f_busoff
);
  fc_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (st_q == FC_BUSOFF) begin
      if (recover) st_d = FC_ACTIVE;
    end else if (tec_d >= TEC_W'(BUSOFF_AT))
      st_d = FC_BUSOFF;
    else if (tec_d > TEC_W'(PASSIVE_ABOVE) || rec_d > REC_W'(PASSIVE_ABOVE))
      st_d = FC_PASSIVE;
    else
      st_d = FC_ACTIVE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      st_q <= FC_ACTIVE;
    else
      st_q <= st_d;
  end

  assign busoff    = (st_q == FC_BUSOFF);
  assign f_active  = (st_q == FC_ACTIVE);
  assign f_passive = (st_q == FC_PASSIVE);
  assign f_busoff  = busoff;

  // R11: exactly one flag
  a_r11_one_flag: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({f_active, f_passive, f_busoff}) == 1);
  // R9: bus-off is held until recovery
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (busoff && !recover) |=> busoff);
endmodule

// File: rtl/can_fault_counters.sv
module can_fault_counters #(
  parameter int TEC_W         = 9,
  parameter int REC_W         = 8,
  parameter int TX_STEP       = 8,
  parameter int RX_STEP_MINOR = 1,
  parameter int RX_STEP_MAJOR = 8,
  parameter int PASSIVE_ABOVE = 127,
  parameter int BUSOFF_AT     = 256,
  parameter int SNAP_ABOVE    = 128,
  parameter int SNAP_TO       = 120
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_err,
  input  logic             tx_ok,
  input  logic             rx_err,
  input  logic             rx_err_major,
  input  logic             rx_ok,
  input  logic             recover,
  output logic [TEC_W-1:0] tx_cnt,
  output logic [REC_W-1:0] rx_cnt,
  output logic             st_active,
  output logic             st_passive,
  output logic             st_busoff
);
  logic             busoff;
  logic             clr;
  logic [TEC_W-1:0] tec_d;
  logic [REC_W-1:0] rec_d;

  assign clr = busoff & recover;

  fc_tx_counter #(.W(TEC_W), .UP(TX_STEP)) u_tx (
    .clk(clk), .rst_n(rst_n), .freeze(busoff), .clr(clr),
    .inc(tx_err), .dec(tx_ok), .cnt_q(tx_cnt), .cnt_d(tec_d)
  );

  fc_rx_counter #(
    .W(REC_W), .STEP_MINOR(RX_STEP_MINOR), .STEP_MAJOR(RX_STEP_MAJOR),
    .SNAP_ABOVE(SNAP_ABOVE), .SNAP_TO(SNAP_TO)
  ) u_rx (
    .clk(clk), .rst_n(rst_n), .freeze(busoff), .clr(clr),
    .inc(rx_err), .major(rx_err_major), .dec(rx_ok),
    .cnt_q(rx_cnt), .cnt_d(rec_d)
  );

  fc_state_fsm #(
    .TEC_W(TEC_W), .REC_W(REC_W),
    .PASSIVE_ABOVE(PASSIVE_ABOVE), .BUSOFF_AT(BUSOFF_AT)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .recover(recover),
    .tec_d(tec_d), .rec_d(rec_d), .busoff(busoff),
    .f_active(st_active), .f_passive(st_passive), .f_busoff(st_busoff)
  );

  // R10: recovery from bus-off clears counters and returns to active
  a_r10_recover: assert property (@(posedge clk) disable iff (!rst_n)
    (st_busoff && recover) |=> (tx_cnt == '0 && rx_cnt == '0 && st_active));
  // R8: reaching the bus-off count sets the bus-off flag
  a_r8_busoff: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_cnt >= TEC_W'(BUSOFF_AT)) |-> st_busoff);
endmodule

// File: tb/tb_can_fault_counters.sv
module tb_can_fault_counters;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_err = 0, tx_ok = 0, rx_err = 0, rx_err_major = 0, rx_ok = 0, recover = 0;
  logic [8:0] tx_cnt;
  logic [7:0] rx_cnt;
  logic st_active, st_passive, st_busoff;

  int n_vec = 0, n_bad = 0;
  int m_tec = 0, m_rec = 0, m_st = 0; // 0 active, 1 passive, 2 bus-off
  bit done = 0;

  always #10 clk = ~clk;

  can_fault_counters dut (
    .clk(clk), .rst_n(rst_n), .tx_err(tx_err), .tx_ok(tx_ok), .rx_err(rx_err),
    .rx_err_major(rx_err_major), .rx_ok(rx_ok), .recover(recover),
    .tx_cnt(tx_cnt), .rx_cnt(rx_cnt),
    .st_active(st_active), .st_passive(st_passive), .st_busoff(st_busoff)
  );

  task automatic check(input string req);
    logic [2:0] exp_f;
    exp_f = {m_st == 2, m_st == 1, m_st == 0};
    n_vec++;
    if (int'(tx_cnt) != m_tec || int'(rx_cnt) != m_rec ||
        {st_busoff, st_passive, st_active} != exp_f) begin
      n_bad++;
      $display("FAIL %s: tec=%0d rec=%0d flags=%b expected tec=%0d rec=%0d flags=%b",
               req, tx_cnt, rx_cnt, {st_busoff, st_passive, st_active},
               m_tec, m_rec, exp_f);
    end
  endtask

  // arithmetic model of R2..R10
  task automatic model(input bit te, to, re, rm, ro, rc);
    if (m_st == 2) begin
      if (rc) begin m_tec = 0; m_rec = 0; m_st = 0; end
    end else begin
      if (te) m_tec = (m_tec + 8 > 511) ? 511 : m_tec + 8;
      else if (to) m_tec = (m_tec > 0) ? m_tec - 1 : 0;
      if (re) m_rec = (m_rec + (rm ? 8 : 1) > 255) ? 255 : m_rec + (rm ? 8 : 1);
      else if (ro) m_rec = (m_rec > 128) ? 120 : ((m_rec > 0) ? m_rec - 1 : 0);
      m_st = (m_tec >= 256) ? 2 : ((m_tec > 127 || m_rec > 127) ? 1 : 0);
    end
  endtask

  task automatic apply(input bit te, to, re, rm, ro, rc, input string req);
    tx_err = te; tx_ok = to; rx_err = re; rx_err_major = rm; rx_ok = ro; recover = rc;
    model(te, to, re, rm, ro, rc);
    @(negedge clk);
    check(req);
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: expired, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] lf;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset");

    // R3 floor at 0, R5 floor at 0
    apply(0, 1, 0, 0, 1, 0, "R3 R5 floor");
    // R2 climb into passive (R7) and bus-off (R8)
    for (int i = 0; i < 15; i++) apply(1, 0, 0, 0, 0, 0, "R2 tx step");
    apply(1, 0, 0, 0, 0, 0, "R7 tec 128 passive");
    apply(0, 1, 0, 0, 0, 0, "R7 tec 127 active");
    apply(1, 1, 0, 0, 0, 0, "R6 tx priority");
    for (int i = 0; i < 17; i++) apply(1, 0, 0, 0, 0, 0, "R8 climb");
    // R9 ignore events in bus-off
    apply(1, 1, 1, 1, 1, 0, "R9 frozen");
    apply(0, 1, 0, 0, 1, 0, "R9 frozen");
    // R10 recovery
    apply(0, 0, 0, 0, 0, 1, "R10 recover");
    apply(0, 0, 0, 0, 0, 1, "R10 recover ignored");
    // R4 minor and major, saturation
    apply(0, 0, 1, 0, 0, 0, "R4 minor");
    for (int i = 0; i < 34; i++) apply(0, 0, 1, 1, 0, 0, "R4 major sat");
    apply(0, 0, 1, 1, 1, 0, "R6 rx priority");
    apply(0, 0, 0, 0, 1, 0, "R5 snap");
    for (int i = 0; i < 9; i++) apply(0, 0, 1, 0, 0, 0, "R4 minor up");
    apply(0, 0, 0, 0, 1, 0, "R5 at 129 snaps");
    for (int i = 0; i < 8; i++) apply(0, 0, 1, 0, 0, 0, "R4 to 128");
    apply(0, 0, 0, 0, 1, 0, "R5 at 128 decrements");
    apply(0, 0, 1, 0, 0, 0, "R7 rec 128 passive");

    // pseudo-random sweep (R11 on every vector)
    lf = 16'hACE1;
    for (int i = 0; i < 20000; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      apply(lf[0] & lf[1], lf[2], lf[3] & lf[4], lf[5] & lf[6], lf[7],
            lf[8] & lf[9] & lf[11], "R11 sweep");
    end

    // reset mid-run returns to R1 state
    apply(1, 0, 1, 1, 0, 0, "R2 pre-reset");
    rst_n = 1'b0; m_tec = 0; m_rec = 0; m_st = 0;
    tx_err = 0; rx_err = 0; rx_err_major = 0;
    #3;
    check("R1 async reset");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule